// File: doc/BRIEF.md
# Single-Bank DRAM Access and Refresh Sequencer

This block sits between a simple host port and one bank of DRAM. It turns each host request into a fixed sequence of phases. First comes an activate phase, which puts the row half of the address on a shared address bus while the row strobe is low. Next comes a column phase, which puts the column half on the same bus while the column strobe is low. A read enables the device output for the column phase; a write drives the data lines and the write enable. The row strobe then stays low until the minimum row-open time has passed. A precharge phase closes the row before anything else may start.

The device needs periodic refresh, and the block schedules it itself. An interval timer raises a pending flag once per refresh interval, which is the refresh period divided by the number of rows. The next time the sequencer is idle, it runs a strobe-only refresh cycle on the row given by an internal wrapping counter, before it takes any further host request. All device timings are parameters counted in clock cycles. The integrator chooses them by rounding each nanosecond limit up to a whole number of clock periods.

Top module: `dram_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four strobes are high (inactive), the data lines are not driven, `rd_valid` is low and `req_ready` is high. A request cut short by reset produces no column cycle.
- R2: An access opens with the row strobe low and the row address on the bus. The row address is taken from `req_addr[ROW_W+COL_W-1:COL_W]`. The row strobe is low for exactly T_RCD cycles before the column strobe falls. The column strobe then falls with the column address `req_addr[COL_W-1:0]` on the bus.
- R3: The column strobe stays low for exactly T_CL cycles and only while the row strobe is low. For a write (`req_write`=1), the write enable is low, the output enable is high and `dram_dq_out` carries the write data with `dram_dq_oe`=1. For a read, the output enable is low, the write enable is high and the lines are not driven.
- R4: In an access, the row strobe stays low for max(T_RAS, T_RCD+T_CL) cycles. Every activation is preceded by at least T_RP cycles of the row strobe high.
- R5: Read data is sampled from `dram_dq_in` at the end of the last column cycle. It appears on `rd_data` with a one-cycle `rd_valid` pulse, T_RCD+T_CL+1 cycles after the accepting edge, and it equals the data last written to that address.
- R6: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the whole access, including its T_RP precharge cycles.
- R7: Every REF_PERIOD_CYC/2^ROW_W cycles a refresh becomes pending. A pending refresh holds `req_ready` low and is issued from idle ahead of any host request.
- R8: A refresh cycle holds the row strobe low for exactly T_RAS cycles. The column strobe, write enable and output enable stay high throughout. It is followed by T_RP precharge cycles.
- R9: Refreshed rows start at 0 after reset, advance by one per refresh, and wrap from row 2^ROW_W-1 back to 0.
- R10: The refresh timer keeps counting during host accesses. After N cycles from reset, the number of completed refreshes is floor(N/interval) or one less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the device |
| dram_dq_oe | output | 1 | Data line drive enable |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
The embedded properties watch the strobe timing on every cycle. They check that the column strobe only appears inside a row-open window, that the row-to-column delay and the minimum row-open time are met, and that each activation is preceded by a full precharge. They also check that the write enable always comes with driven data, that `rd_valid` is a single pulse, and that a refresh is only started while one is pending. Only the bench scenarios, with their device model, can show that data written at one address is read back there. They also show the correct row and column values on the bus, the exact refresh row order across a wrap, the refresh rate holding up under host traffic, and the effect of a reset in mid-access.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_HOLD,
    ST_RACT,
    ST_PRE
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addr_sel_t;

endpackage

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int ROW_W        = 4,
  parameter int REF_INTERVAL = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);

  localparam int TMR_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             pend_q, pend_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             expire;
  logic             row_en;

  assign expire = (tmr_q == TMR_LAST);
  assign row_en = ref_done;

  always_comb begin
    tmr_d  = expire ? '0 : tmr_q + TMR_W'(1);
    // expiry wins over clearing, so a request is never lost
    pend_d = expire ? 1'b1 : (ref_start ? 1'b0 : pend_q);
    row_d  = row_q + ROW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      tmr_q  <= tmr_d;
      pend_q <= pend_d;
      if (row_en) row_q <= row_d;
    end
  end

  assign ref_pending = pend_q;
  assign ref_row     = row_q;

  // R7: the sequencer may only launch a refresh that is actually pending
  a_r7_start_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |-> ref_pending);

  // R9: the refresh row only moves when a refresh completes
  a_r9_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ref_done) |-> $stable(ref_row));

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_ctl_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_CL  = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      req_write,
  input  logic      ref_pending,
  output logic      req_ready,
  output logic      accept,
  output logic      ref_start,
  output logic      ref_done,
  output logic      cap_en,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n,
  output logic      oe_n,
  output logic      dq_oe,
  output addr_sel_t addr_sel
);

  localparam int HOLD_CYC = (T_RAS > T_RCD + T_CL) ? (T_RAS - T_RCD - T_CL) : 0;
  localparam int HOLD_M1  = (HOLD_CYC > 0) ? HOLD_CYC - 1 : 0;
  localparam int T_MAX    = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                           : ((T_RP > T_CL) ? T_RP : T_CL);
  localparam int CNT_W    = $clog2(T_MAX + 1) + 1;

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             refc_q, refc_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    wr_d      = wr_q;
    refc_d    = refc_q;
    ref_start = 1'b0;
    ref_done  = 1'b0;
    accept    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pending) begin
          state_d   = ST_RACT;
          cnt_d     = CNT_W'(T_RAS - 1);
          refc_d    = 1'b1;
          ref_start = 1'b1;
        end else if (req_valid) begin
          state_d = ST_ACT;
          cnt_d   = CNT_W'(T_RCD - 1);
          wr_d    = req_write;
          refc_d  = 1'b0;
          accept  = 1'b1;
        end
      end
      ST_ACT: begin
        if (cnt_zero) begin
          state_d = ST_COL;
          cnt_d   = CNT_W'(T_CL - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_COL: begin
        if (cnt_zero) begin
          if (HOLD_CYC > 0) begin
            state_d = ST_HOLD;
            cnt_d   = CNT_W'(HOLD_M1);
          end else begin
            state_d = ST_PRE;
            cnt_d   = CNT_W'(T_RP - 1);
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_HOLD, ST_RACT: begin
        if (cnt_zero) begin
          state_d = ST_PRE;
          cnt_d   = CNT_W'(T_RP - 1);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_PRE: begin
        if (cnt_zero) begin
          state_d  = ST_IDLE;
          ref_done = refc_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      refc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      refc_q  <= refc_d;
    end
  end

  always_comb begin
    ras_n    = !(state_q == ST_ACT || state_q == ST_COL ||
                 state_q == ST_HOLD || state_q == ST_RACT);
    cas_n    = (state_q != ST_COL);
    we_n     = !(state_q == ST_COL && wr_q);
    oe_n     = !(state_q == ST_COL && !wr_q);
    dq_oe    = (state_q == ST_COL) && wr_q;
    cap_en   = (state_q == ST_COL) && cnt_zero && !wr_q;
    req_ready = (state_q == ST_IDLE) && !ref_pending;
    unique case (state_q)
      ST_ACT:           addr_sel = SEL_ROW;
      ST_COL, ST_HOLD:  addr_sel = SEL_COL;
      ST_RACT:          addr_sel = SEL_REF;
      default:          addr_sel = SEL_NONE;
    endcase
  end

  // R6: once accepted, the next cycle is an activation, not idle
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready && !ras_n);

  // R8: a refresh launch opens the row without any column strobe
  a_r8_refresh_no_column: assert property (@(posedge clk) disable iff (!rst_n)
    ref_start |=> !ras_n && cas_n && we_n && oe_n);

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int BUS_W = 4
) (
  input  addr_sel_t        sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [BUS_W-1:0] bus
);

  logic [BUS_W-1:0] row_ext, col_ext, ref_ext;

  generate
    if (BUS_W > ROW_W) begin : g_row_pad
      assign row_ext = {{(BUS_W-ROW_W){1'b0}}, row};
      assign ref_ext = {{(BUS_W-ROW_W){1'b0}}, ref_row};
    end else begin : g_row_full
      assign row_ext = row;
      assign ref_ext = ref_row;
    end
    if (BUS_W > COL_W) begin : g_col_pad
      assign col_ext = {{(BUS_W-COL_W){1'b0}}, col};
    end else begin : g_col_full
      assign col_ext = col;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_ROW: bus = row_ext;
      SEL_COL: bus = col_ext;
      SEL_REF: bus = ref_ext;
      default: bus = '0;
    endcase
  end

endmodule

// File: rtl/dram_ctl.sv
module dram_ctl
  import dram_ctl_pkg::*;
#(
  parameter int ROW_W          = 4,
  parameter int COL_W          = 4,
  parameter int DATA_W         = 8,
  parameter int T_RCD          = 3,
  parameter int T_CL           = 2,
  parameter int T_RAS          = 6,
  parameter int T_RP           = 3,
  parameter int REF_PERIOD_CYC = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                     dram_ras_n,
  output logic                     dram_cas_n,
  output logic                     dram_we_n,
  output logic                     dram_oe_n,
  output logic [DATA_W-1:0]        dram_dq_out,
  output logic                     dram_dq_oe,
  input  logic [DATA_W-1:0]        dram_dq_in
);

  localparam int BUS_W        = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ADDR_W       = ROW_W + COL_W;
  localparam int REF_INTERVAL = REF_PERIOD_CYC / (1 << ROW_W);
  localparam int CHK_MAX      = T_RAS + T_RP + T_RCD + T_CL + 2;
  localparam int CHK_W        = $clog2(CHK_MAX + 1);

  logic             accept, ref_start, ref_done, ref_pending, cap_en;
  logic [ROW_W-1:0] ref_row;
  addr_sel_t        addr_sel;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q, rvalid_d;

  dram_ref_sched #(
    .ROW_W        (ROW_W),
    .REF_INTERVAL (REF_INTERVAL)
  ) ref_sched_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_start   (ref_start),
    .ref_done    (ref_done),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dram_seq #(
    .T_RCD (T_RCD),
    .T_CL  (T_CL),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .ref_pending (ref_pending),
    .req_ready   (req_ready),
    .accept      (accept),
    .ref_start   (ref_start),
    .ref_done    (ref_done),
    .cap_en      (cap_en),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .dq_oe       (dram_dq_oe),
    .addr_sel    (addr_sel)
  );

  dram_addr_mux #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .BUS_W (BUS_W)
  ) addr_mux_i (
    .sel     (addr_sel),
    .row     (addr_q[ADDR_W-1:COL_W]),
    .col     (addr_q[COL_W-1:0]),
    .ref_row (ref_row),
    .bus     (dram_addr)
  );

  assign rvalid_d = cap_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_en) rdata_q <= dram_dq_in;
    end
  end

  assign rd_data     = rdata_q;
  assign rd_valid    = rvalid_q;
  assign dram_dq_out = wdata_q;

  // ---- strobe-timing observers (checker state only) ----
  logic [CHK_W-1:0] ras_lo_cnt, ras_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= CHK_W'(CHK_MAX);
    end else begin
      if (dram_ras_n) ras_lo_cnt <= '0;
      else if (ras_lo_cnt != CHK_W'(CHK_MAX)) ras_lo_cnt <= ras_lo_cnt + CHK_W'(1);
      if (!dram_ras_n) ras_hi_cnt <= '0;
      else if (ras_hi_cnt != CHK_W'(CHK_MAX)) ras_hi_cnt <= ras_hi_cnt + CHK_W'(1);
    end
  end

  a_r3_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  a_r2_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> ras_lo_cnt >= CHK_W'(T_RCD));

  a_r4_row_open_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> ras_lo_cnt >= CHK_W'(T_RAS));

  a_r4_precharge_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> ras_hi_cnt >= CHK_W'(T_RP));

  a_r3_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_dq_oe && !dram_cas_n && dram_oe_n);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_ready_row_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dram_ras_n && dram_cas_n);

endmodule

// File: tb/dram_ctl_tb_top.sv
module dram_ctl_tb_top;

  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 3, T_CL = 2, T_RAS = 6, T_RP = 3;
  localparam int REF_PERIOD_CYC = 512;
  localparam int REF_INT   = REF_PERIOD_CYC / (1 << ROW_W);
  localparam int ACC_LO    = (T_RAS > T_RCD + T_CL) ? T_RAS : T_RCD + T_CL;
  localparam int ACC_TOTAL = ACC_LO + T_RP;
  localparam int NVEC = 13;
  // {write, address, data}; for reads data is the expected value
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b1, 8'hFF, 8'h3C}, {1'b1, 8'h0F, 8'h81},
    {1'b1, 8'hF0, 8'h7E}, {1'b0, 8'h00, 8'hA5}, {1'b0, 8'hFF, 8'h3C},
    {1'b1, 8'h00, 8'h12}, {1'b0, 8'h00, 8'h12}, {1'b0, 8'h0F, 8'h81},
    {1'b0, 8'hF0, 8'h7E}, {1'b0, 8'h55, 8'h00}, {1'b1, 8'h55, 8'hC3},
    {1'b0, 8'h55, 8'hC3}
  };

  logic clk, rst_n;
  logic req_valid, req_ready, req_write, rd_valid;
  logic [7:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rd_data, dq_out, dq_in;
  logic [3:0] dram_addr;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;

  dram_ctl dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_data (rd_data), .rd_valid (rd_valid),
    .dram_addr (dram_addr), .dram_ras_n (ras_n), .dram_cas_n (cas_n),
    .dram_we_n (we_n), .dram_oe_n (oe_n),
    .dram_dq_out (dq_out), .dram_dq_oe (dq_oe), .dram_dq_in (dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // ---- device model and bus monitor ----
  logic [7:0] mem [256];
  logic [3:0] row_at_fall;
  logic [3:0] host_row, host_col;
  logic       host_wr;
  logic [7:0] host_data;
  bit in_low, cas_seen, ctl_low, ready_before, prev_ready;
  int low_len, cas_len, hi_len, cyc, ref_cnt;
  logic [3:0] exp_ref;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  assign dq_in = (!cas_n && !oe_n) ? mem[{row_at_fall, dram_addr}] : 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      in_low = 0; hi_len = T_RP; exp_ref = 0; ref_cnt = 0; cyc = 0;
      prev_ready = 1; row_at_fall = 0;
    end else begin
      cyc++;
      if (!ras_n) begin
        if (!in_low) begin
          chk(hi_len >= T_RP, "R4 precharge before activate", hi_len, T_RP);
          in_low = 1; low_len = 1; cas_len = 0; cas_seen = 0; ctl_low = 0;
          row_at_fall = dram_addr; ready_before = prev_ready;
        end else low_len++;
        if (!we_n || !oe_n) ctl_low = 1;
        if (!cas_n) begin
          if (!cas_seen) begin
            cas_seen = 1;
            chk(low_len - 1 == T_RCD, "R2 row-to-column delay", low_len - 1, T_RCD);
            chk(row_at_fall == host_row, "R2 row address", row_at_fall, host_row);
            chk(dram_addr == host_col, "R2 column address", dram_addr, host_col);
          end
          cas_len++;
          if (host_wr) begin
            chk(!we_n && oe_n && dq_oe && dq_out == host_data, "R3 write controls",
                {we_n, oe_n, dq_oe}, 3'b011);
            mem[{row_at_fall, dram_addr}] = dq_out;
          end else
            chk(we_n && !oe_n && !dq_oe, "R3 read controls", {we_n, oe_n, dq_oe}, 3'b100);
        end
      end else begin
        if (in_low) begin
          in_low = 0; hi_len = 1;
          if (cas_seen) begin
            chk(low_len == ACC_LO, "R4 access row-open length", low_len, ACC_LO);
            chk(cas_len == T_CL, "R3 column strobe length", cas_len, T_CL);
          end else begin
            chk(low_len == T_RAS, "R8 refresh row-open length", low_len, T_RAS);
            chk(!ctl_low, "R8 refresh keeps we/oe high", ctl_low, 0);
            chk(row_at_fall == exp_ref, "R9 refresh row order", row_at_fall, exp_ref);
            chk(!ready_before, "R7 refresh only while host blocked", ready_before, 0);
            exp_ref = exp_ref + 4'd1;
            ref_cnt++;
          end
        end else hi_len++;
      end
      prev_ready = req_ready;
    end
  end

  // ---- host access task ----
  task automatic do_access(input bit wr, input logic [7:0] a, input logic [7:0] d);
    int rv_at = 0;
    int ready_hi = 0;
    while (!req_ready) @(negedge clk);
    host_wr = wr; host_row = a[7:4]; host_col = a[3:0]; host_data = d;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int n = 1; n <= ACC_TOTAL + 1; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 0;
      if (n <= ACC_TOTAL && req_ready) ready_hi++;
      if (rd_valid) begin
        if (rv_at == 0) rv_at = n;
        if (!wr) chk(rd_data == d, "R5 read data", rd_data, d);
      end
    end
    chk(ready_hi == 0, "R6 ready low through precharge", ready_hi, 0);
    if (!wr) chk(rv_at == T_RCD + T_CL + 1, "R5 read latency", rv_at, T_RCD + T_CL + 1);
    else     chk(rv_at == 0, "R5 no rd_valid on write", rv_at, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    host_wr = 0; host_row = 0; host_col = 0; host_data = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle in reset",
        {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !rd_valid, "R1 no drive, no rd_valid", {dq_oe, rd_valid}, 0);
    chk(req_ready, "R1 ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && ras_n, "R1 ready after reset", {req_ready, ras_n}, 3);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      do_access(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
      repeat (i % 3) @(negedge clk);
    end

    // idle long enough for the refresh row counter to wrap
    repeat (700) @(negedge clk);
    chk(ref_cnt >= cyc / REF_INT - 1 && ref_cnt <= cyc / REF_INT,
        "R10 refresh rate under traffic", ref_cnt, cyc / REF_INT);
    chk(ref_cnt > (1 << ROW_W), "R9 row counter wrapped", ref_cnt, (1 << ROW_W) + 1);

    // reset in the middle of an access
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h77; req_wdata = 8'h99;
    @(posedge clk);
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(ras_n && cas_n && !dq_oe, "R1 reset aborts access", {ras_n, cas_n, dq_oe}, 6);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after mid-access reset", req_ready, 1);
    do_access(0, 8'h77, 8'h00);
    do_access(0, 8'hFF, 8'h3C);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule